// File: doc/BRIEF.md
# Ternary Lookup Array Write Controller

This block sits on the device side of a lookup memory that keeps a data array and a mask array. It watches a host command bus and the 72-bit data bus and turns each accepted write command into one or more single-cycle write strobes towards the arrays. Each strobe carries an array select, a 16-bit location address, 72 bits of data and a 4-bit global-mask index.

A write begins with an address phase of two consecutive clock ticks (A and B). During that phase the opcode is held on the command bus with the valid flag high and the address word is on the data bus. One or more data ticks follow, then one idle tick. A single write always stores one location. A burst write stores as many locations as the length input asks for, on consecutive data ticks, and an internal counter steps the address. When several devices share the bus, a device only writes if the address word carries its own ID or the all-ones broadcast code. A command that names another device, or an array code that is not defined, still runs through all its phases, but nothing is written.

Top module: `tcam_wr_ctrl`

## Requirements
- R1: While reset is held and afterwards, until a command is accepted, `busy` and `wr_en` are 0.
- R2: A write is accepted when `cmd_vld`=1, `cmd[1:0]`=01 and `cmd[9]`=0 on tick A. The same must hold on tick B, which follows. The next tick is the data tick, and the strobe `wr_en` is high for exactly the one cycle that follows it. During that cycle `wr_data` holds the bus value from the data tick and `wr_addr` holds `dq_in[15:0]` from tick A.
- R3: `busy` is high from the cycle after tick A until the trailing idle tick ends. Command inputs seen while `busy` is high are ignored, and that includes the data and idle ticks.
- R4: `cmd[2]`=1 selects a burst of `burst_len` locations, and a length of 0 counts as 1. The data ticks are back to back. Strobe k carries address base+k, modulo 2^16. With `cmd[2]`=0 the block stores one location and `burst_len` has no effect.
- R5: The device is selected when `dq_in[25:21]` equals `dev_id` or equals 11111. A device that is not selected emits no strobe, but its `busy` timing is the same as for a selected one.
- R6: `dq_in[20:19]`=00 gives `wr_arr`=0 (data array) and 01 gives `wr_arr`=1 (mask array). Codes 10 and 11 emit no strobe.
- R7: `wr_gmi` equals {`cmd[10]`,`cmd[5:3]`} as sampled on tick A, and it stays the same for every strobe of a burst.
- R8: A command with `cmd[9]`=1 or with an opcode other than 01 is not accepted, and `busy` stays 0.
- R9: If the tick after A does not repeat a valid write command, the command is dropped: no strobe is emitted and `busy` falls one cycle later.
- R10: On tick A, `dq_in[71:26]`, `dq_in[18:16]` and `cmd[8:6]` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Command valid |
| cmd | input | 11 | Command bus: opcode, form, mask index, mode |
| dq_in | input | 72 | Address word on address ticks, write data on data ticks |
| dev_id | input | 5 | ID of this device in the cascade |
| burst_len | input | 4 | Number of locations in a burst write |
| busy | output | 1 | A write command is in progress |
| wr_en | output | 1 | One-cycle array write strobe |
| wr_arr | output | 1 | 0 = data array, 1 = mask array |
| wr_addr | output | 16 | Location address |
| wr_data | output | 72 | Data to store |
| wr_gmi | output | 4 | Global-mask register index |

## Verification
The bench drives inputs on the falling edge and reads outputs on the next falling edge. Tick A is sampled at rising edge 0, so `busy` is first visible at the falling edge that follows. Data tick i is sampled at rising edge 2+i, so its strobe is read one falling edge later, when the next data word is driven. After the last strobe, `busy` is checked high for one more falling edge (the idle tick) and low on the falling edge after that. A dropped or rejected command is checked by reading `busy` and `wr_en` on those same edges.

// File: rtl/tcam_wr_pkg.sv
package tcam_wr_pkg;
  // Command bus field positions
  localparam int CMD_W       = 11;
  localparam int OP_LSB      = 0;
  localparam int FORM_BIT    = 2;
  localparam int GMI_LO_LSB  = 3;
  localparam int MODE_BIT    = 9;
  localparam int GMI_HI_BIT  = 10;
  localparam int GMI_W       = 4;

  localparam logic [1:0] OP_WRITE = 2'b01;

  // Address word field positions
  localparam int ID_LSB      = 21;
  localparam int ARR_LSB     = 19;
  localparam logic [1:0] ARR_DATA = 2'b00;
  localparam logic [1:0] ARR_MASK = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDRB = 2'd1,
    ST_DATA  = 2'd2,
    ST_GAP   = 2'd3
  } wr_state_e;
endpackage

// File: rtl/tcam_wr_rst_sync.sv
module tcam_wr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tcam_wr_decode.sv
module tcam_wr_decode
  import tcam_wr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ID_W   = 5,
  localparam int FLD_W = ID_LSB + ID_W
) (
  input  logic              cmd_vld,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [FLD_W-1:0]  dq_fld,
  input  logic [ID_W-1:0]   dev_id,
  output logic              cmd_ok,
  output logic              burst,
  output logic              sel_hit,
  output logic              arr_mask,
  output logic [ADDR_W-1:0] loc_addr,
  output logic [GMI_W-1:0]  gmi
);
  logic [ID_W-1:0] tgt_id;
  logic [1:0]      arr_code;
  logic            id_match;
  logic            arr_known;
  logic            unused_fld;

  always_comb begin
    tgt_id    = dq_fld[ID_LSB +: ID_W];
    arr_code  = dq_fld[ARR_LSB +: 2];
    cmd_ok    = cmd_vld && (cmd[OP_LSB +: 2] == OP_WRITE) && !cmd[MODE_BIT];
    burst     = cmd[FORM_BIT];
    id_match  = (tgt_id == dev_id) || (tgt_id == {ID_W{1'b1}});
    arr_known = (arr_code == ARR_DATA) || (arr_code == ARR_MASK);
    sel_hit   = id_match && arr_known;
    arr_mask  = (arr_code == ARR_MASK);
    loc_addr  = dq_fld[ADDR_W-1:0];
    gmi       = {cmd[GMI_HI_BIT], cmd[GMI_LO_LSB +: 3]};
  end

  assign unused_fld = ^{cmd[8:6], dq_fld[ARR_LSB-1:ADDR_W]};
endmodule

// File: rtl/tcam_wr_fsm.sv
module tcam_wr_fsm
  import tcam_wr_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_ok,
  input  logic             burst,
  input  logic [LEN_W-1:0] burst_len,
  output logic             load,
  output logic             data_cyc,
  output logic             busy
);
  wr_state_e        state_q, state_d;
  logic [LEN_W-1:0] remain_q, remain_d;

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    case (state_q)
      ST_IDLE: begin
        if (cmd_ok) begin
          state_d = ST_ADDRB;
          if (burst && (burst_len != '0)) remain_d = burst_len;
          else                            remain_d = LEN_W'(1);
        end
      end
      ST_ADDRB: state_d = cmd_ok ? ST_DATA : ST_IDLE;
      ST_DATA: begin
        if (remain_q == LEN_W'(1)) state_d  = ST_GAP;
        else                       remain_d = remain_q - LEN_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
    end
  end

  assign load     = (state_q == ST_IDLE) && cmd_ok;
  assign data_cyc = (state_q == ST_DATA);
  assign busy     = (state_q != ST_IDLE);
endmodule

// File: rtl/tcam_wr_addr.sv
module tcam_wr_addr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] cur
);
  logic [ADDR_W-1:0] cur_d;

  always_comb begin
    cur_d = cur;
    if (load)     cur_d = load_val;
    else if (inc) cur_d = cur + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= cur_d;
  end
endmodule

// File: rtl/tcam_wr_ctrl.sv
module tcam_wr_ctrl
  import tcam_wr_pkg::*;
#(
  parameter int DQ_W   = 72,
  parameter int ADDR_W = 16,
  parameter int ID_W   = 5,
  parameter int LEN_W  = 4,
  localparam int FLD_W = ID_LSB + ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DQ_W-1:0]   dq_in,
  input  logic [ID_W-1:0]   dev_id,
  input  logic [LEN_W-1:0]  burst_len,
  output logic              busy,
  output logic              wr_en,
  output logic              wr_arr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DQ_W-1:0]   wr_data,
  output logic [GMI_W-1:0]  wr_gmi
);
  logic              rst_n_s;
  logic              cmd_ok, burst, sel_hit, arr_mask;
  logic [ADDR_W-1:0] loc_addr, cur_addr;
  logic [GMI_W-1:0]  gmi;
  logic              load, data_cyc;

  // Latched command attributes
  logic              hit_q, hit_d;
  logic              arr_q, arr_d;
  logic [GMI_W-1:0]  gmi_q, gmi_d;

  // Output strobe stage
  logic              en_q, en_d;
  logic              oarr_q, oarr_d;
  logic [ADDR_W-1:0] oaddr_q, oaddr_d;
  logic [DQ_W-1:0]   odata_q, odata_d;
  logic [GMI_W-1:0]  ogmi_q, ogmi_d;

  tcam_wr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  tcam_wr_decode #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_dec (
    .cmd_vld(cmd_vld), .cmd(cmd), .dq_fld(dq_in[FLD_W-1:0]), .dev_id(dev_id),
    .cmd_ok(cmd_ok), .burst(burst), .sel_hit(sel_hit), .arr_mask(arr_mask),
    .loc_addr(loc_addr), .gmi(gmi)
  );

  tcam_wr_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .cmd_ok(cmd_ok), .burst(burst),
    .burst_len(burst_len), .load(load), .data_cyc(data_cyc), .busy(busy)
  );

  tcam_wr_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n_s), .load(load), .load_val(loc_addr),
    .inc(data_cyc), .cur(cur_addr)
  );

  always_comb begin
    hit_d   = hit_q;
    arr_d   = arr_q;
    gmi_d   = gmi_q;
    if (load) begin
      hit_d = sel_hit;
      arr_d = arr_mask;
      gmi_d = gmi;
    end
    en_d    = data_cyc && hit_q;
    oarr_d  = oarr_q;
    oaddr_d = oaddr_q;
    odata_d = odata_q;
    ogmi_d  = ogmi_q;
    if (data_cyc) begin
      oarr_d  = arr_q;
      oaddr_d = cur_addr;
      odata_d = dq_in;
      ogmi_d  = gmi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      hit_q   <= 1'b0;
      arr_q   <= 1'b0;
      gmi_q   <= '0;
      en_q    <= 1'b0;
      oarr_q  <= 1'b0;
      oaddr_q <= '0;
      odata_q <= '0;
      ogmi_q  <= '0;
    end else begin
      hit_q   <= hit_d;
      arr_q   <= arr_d;
      gmi_q   <= gmi_d;
      en_q    <= en_d;
      oarr_q  <= oarr_d;
      oaddr_q <= oaddr_d;
      odata_q <= odata_d;
      ogmi_q  <= ogmi_d;
    end
  end

  assign wr_en   = en_q;
  assign wr_arr  = oarr_q;
  assign wr_addr = oaddr_q;
  assign wr_data = odata_q;
  assign wr_gmi  = ogmi_q;
endmodule

// File: rtl/tcam_wr_ctrl_chk.sv
module tcam_wr_ctrl_chk
  import tcam_wr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_vld,
  input logic [CMD_W-1:0]  cmd,
  input logic              busy,
  input logic              wr_en,
  input logic              wr_arr,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [GMI_W-1:0]  wr_gmi
);
  logic start_ok;
  assign start_ok = cmd_vld && (cmd[OP_LSB +: 2] == OP_WRITE) && !cmd[MODE_BIT];

  // R2: a strobe always follows a cycle in which a command was in flight
  assert_strobe_in_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(busy));

  // R3: the command ends only after its last strobe has gone
  assert_end_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wr_en);

  // R4: back-to-back strobes step the address by one
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

  // R7: array select and mask index hold across a burst
  assert_attr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> ($stable(wr_gmi) && $stable(wr_arr)));

  // R8: no start without a valid write command
  assert_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_ok) |=> !busy);
endmodule

bind tcam_wr_ctrl tcam_wr_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(cmd), .busy(busy),
  .wr_en(wr_en), .wr_arr(wr_arr), .wr_addr(wr_addr), .wr_gmi(wr_gmi)
);

// File: tb/tcam_wr_ctrl_tb.sv
module tcam_wr_ctrl_tb;
  localparam int CLK_P = 10;
  localparam logic [4:0] MY_ID = 5'h0A;

  logic        clk;
  logic        rst_n;
  logic        cmd_vld;
  logic [10:0] cmd;
  logic [71:0] dq_in;
  logic [4:0]  dev_id;
  logic [3:0]  burst_len;
  logic        busy, wr_en, wr_arr;
  logic [15:0] wr_addr;
  logic [71:0] wr_data;
  logic [3:0]  wr_gmi;

  int n_chk = 0;
  int n_bad = 0;

  tcam_wr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(cmd), .dq_in(dq_in),
    .dev_id(dev_id), .burst_len(burst_len), .busy(busy), .wr_en(wr_en),
    .wr_arr(wr_arr), .wr_addr(wr_addr), .wr_data(wr_data), .wr_gmi(wr_gmi)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [71:0] data_word(input logic [7:0] tag, input int i);
    return {tag, 32'h5A5A0000 | 32'(i), 32'(i * 3 + 1)};
  endfunction

  function automatic logic [10:0] wr_cmd(input logic burst, input logic [3:0] gmi, input bit junk);
    logic [10:0] c;
    c = '0;
    c[1:0]  = 2'b01;
    c[2]    = burst;
    c[5:3]  = gmi[2:0];
    c[8:6]  = junk ? 3'b101 : 3'b000;
    c[10]   = gmi[3];
    return c;
  endfunction

  // One write command, checked strobe by strobe and through its idle tick
  task automatic run_write(input string req, input logic burst, input int len_in,
                           input int nloc, input logic [4:0] id, input logic [1:0] arr,
                           input logic [15:0] addr, input logic [3:0] gmi,
                           input logic [7:0] tag, input bit hit, input bit junk,
                           input bit hold_cmd);
    logic [71:0] aw;
    aw        = junk ? '1 : '0;
    aw[25:21] = id;
    aw[20:19] = arr;
    aw[18:16] = junk ? 3'b111 : 3'b000;
    aw[15:0]  = addr;
    @(negedge clk);
    cmd_vld = 1'b1; cmd = wr_cmd(burst, gmi, junk); dq_in = aw; burst_len = 4'(len_in);
    @(negedge clk);
    chk({req, " R3 busy after A"}, 72'(busy), 72'(1));
    for (int i = 0; i < nloc; i++) begin
      @(negedge clk);
      if (i > 0) chk_strobe(req, i - 1, arr, addr, gmi, tag, hit);
      cmd_vld = hold_cmd;
      dq_in = data_word(tag, i);
    end
    @(negedge clk);
    chk_strobe(req, nloc - 1, arr, addr, gmi, tag, hit);
    chk({req, " R3 busy in idle tick"}, 72'(busy), 72'(1));
    dq_in = '0;
    @(negedge clk);
    chk({req, " R3 busy cleared"}, 72'(busy), 72'(0));
    chk({req, " R2 strobe single cycle"}, 72'(wr_en), 72'(0));
    cmd_vld = 1'b0;
  endtask

  task automatic chk_strobe(input string req, input int k, input logic [1:0] arr,
                            input logic [15:0] addr, input logic [3:0] gmi,
                            input logic [7:0] tag, input bit hit);
    if (hit) begin
      chk({req, " wr_en"}, 72'(wr_en), 72'(1));
      chk({req, " wr_addr"}, 72'(wr_addr), 72'(16'(addr + 16'(k))));
      chk({req, " wr_data"}, wr_data, data_word(tag, k));
      chk({req, " wr_arr"}, 72'(wr_arr), 72'(arr[0]));
      chk({req, " wr_gmi"}, 72'(wr_gmi), 72'(gmi));
    end else begin
      chk({req, " no strobe"}, 72'(wr_en), 72'(0));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cmd_vld = 1'b0; cmd = '0; dq_in = '0; dev_id = MY_ID; burst_len = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", 72'(busy), 72'(0));
    chk("R1 wr_en in reset", 72'(wr_en), 72'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", 72'(busy), 72'(0));
    chk("R1 wr_en after reset", 72'(wr_en), 72'(0));
  endtask

  task automatic t_reject();
    @(negedge clk);
    cmd_vld = 1'b1; cmd = wr_cmd(1'b0, 4'h0, 1'b0); cmd[9] = 1'b1; dq_in = '0;
    @(negedge clk);
    chk("R8 mode bit set", 72'(busy), 72'(0));
    cmd = wr_cmd(1'b0, 4'h0, 1'b0); cmd[1:0] = 2'b10;
    @(negedge clk);
    chk("R8 other opcode", 72'(busy), 72'(0));
    cmd_vld = 1'b0;
    @(negedge clk);
    chk("R8 no strobe", 72'(wr_en), 72'(0));
  endtask

  task automatic t_abort();
    @(negedge clk);
    cmd_vld = 1'b1; cmd = wr_cmd(1'b0, 4'h3, 1'b0);
    dq_in = '0; dq_in[25:21] = MY_ID; dq_in[15:0] = 16'h0042;
    @(negedge clk);
    cmd_vld = 1'b0;
    chk("R9 busy after A", 72'(busy), 72'(1));
    @(negedge clk);
    chk("R9 dropped", 72'(busy), 72'(0));
    for (int i = 0; i < 3; i++) begin
      dq_in = data_word(8'hEE, i);
      @(negedge clk);
      chk("R9 no strobe", 72'(wr_en), 72'(0));
    end
  endtask

  initial begin
    t_reset();
    run_write("R2 single data", 1'b0, 5, 1, MY_ID, 2'b00, 16'h1234, 4'hA, 8'h11, 1, 0, 0);
    run_write("R6 mask array", 1'b0, 0, 1, MY_ID, 2'b01, 16'h0777, 4'h1, 8'h22, 1, 0, 0);
    run_write("R6 bad array 10", 1'b0, 0, 1, MY_ID, 2'b10, 16'h0001, 4'h0, 8'h33, 0, 0, 0);
    run_write("R6 bad array 11", 1'b0, 0, 1, MY_ID, 2'b11, 16'h0002, 4'h0, 8'h34, 0, 0, 0);
    run_write("R4 burst of 4", 1'b1, 4, 4, MY_ID, 2'b00, 16'h0100, 4'h6, 8'h44, 1, 0, 0);
    run_write("R4 burst wrap", 1'b1, 3, 3, MY_ID, 2'b01, 16'hFFFE, 4'hF, 8'h55, 1, 0, 0);
    run_write("R4 burst len 0", 1'b1, 0, 1, MY_ID, 2'b00, 16'h0200, 4'h2, 8'h66, 1, 0, 0);
    run_write("R5 broadcast", 1'b0, 0, 1, 5'h1F, 2'b00, 16'h0300, 4'h4, 8'h77, 1, 0, 0);
    run_write("R5 other device", 1'b1, 2, 2, 5'h0B, 2'b00, 16'h0400, 4'h4, 8'h78, 0, 0, 0);
    run_write("R10 reserved bits", 1'b0, 0, 1, MY_ID, 2'b01, 16'hBEEF, 4'h9, 8'h88, 1, 1, 0);
    run_write("R7 mask index burst", 1'b1, 2, 2, MY_ID, 2'b00, 16'h0500, 4'h5, 8'h99, 1, 0, 0);
    run_write("R3 cmd held busy", 1'b1, 2, 2, MY_ID, 2'b00, 16'h0600, 4'h8, 8'hAA, 1, 0, 1);
    t_reject();
    t_abort();
    run_write("R2 after abort", 1'b0, 0, 1, MY_ID, 2'b00, 16'h0042, 4'h3, 8'hBB, 1, 0, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule